// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit accumulator machine. Each cycle it takes an accumulator operand `a`, a second operand `b` and a 4-bit operation code. It returns the result combinationally, with a write-enable that tells the surrounding datapath whether the result should be stored. Add, subtract, compare, AND, OR, XOR, complement, increment and decrement are provided. Increment and decrement act on `b`, the register operand.

A four-bit status register holds zero, carry, overflow and interrupt-enable. The flags update on the rising clock edge when `en` is high. The same operation code space also reads the status register into the result, writes it from `a`, and sets or clears the interrupt-enable bit. Compare behaves as a subtraction whose result is discarded. Its carry means that `a` is below `b` as unsigned numbers.

There is no stream traffic at this block's edge. Every pin is a plain control or status pin, and the outputs are valid in the same cycle as the inputs. There is no back-pressure to honour.

Top module: `alu8_status_top`

## Requirements
- R1: While `rst_n` is low and after reset releases, all four flags are 0, so `flags` reads 00h.
- R2: ADD (op 0) gives `result` = (a+b) mod 256 and sets `result_we`=1. Carry becomes the unsigned carry-out and overflow becomes the two's-complement signed overflow.
- R3: SUB (op 1) gives `result` = (a-b) mod 256 and sets `result_we`=1. Carry becomes 1 exactly when a < b unsigned, and overflow becomes the signed overflow of a-b.
- R4: CMP (op 2) updates zero, carry and overflow exactly as SUB does, and drives `result_we`=0.
- R5: AND (op 3), OR (op 4), XOR (op 5) and NOT (op 6, which gives ~a) set `result_we`=1 and clear carry and overflow.
- R6: INC (op 7) gives b+1 and DEC (op 8) gives b-1, both mod 256 with `result_we`=1. Overflow is set only when INC sees 7Fh or DEC sees 80h, and carry keeps its value.
- R7: After any of ops 0..8 commits, the zero flag is 1 exactly when the 8-bit arithmetic or logic value was 0. For CMP that value is the discarded difference.
- R8: The flag byte is bit0 zero, bit1 carry, bit2 overflow and bit3 interrupt-enable, with bits 7:4 always 0. It appears on `flags`. Op 9 (read flags) puts this byte on `result` with `result_we`=1 and changes no flag.
- R9: Op 10 (write flags) loads zero, carry, overflow and interrupt-enable from a[0], a[1], a[2] and a[3], and drives `result_we`=0.
- R10: Op 11 sets interrupt-enable and op 12 clears it. No other flag changes with these ops. Ops 0..9 never alter interrupt-enable.
- R11: When `en` is low, no flag changes at the clock edge, whatever the op code.
- R12: Op codes 13, 14 and 15 change no flag and drive `result_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| en | input | 1 | Commit the flag update of the current op at the next edge |
| op | input | 4 | Operation code |
| a | input | 8 | Accumulator operand |
| b | input | 8 | Second operand (register or immediate) |
| result | output | 8 | Combinational result |
| result_we | output | 1 | The result should be written to its destination |
| flags | output | 8 | Flag byte in the R8 layout |

## Verification
Two things meet in a single cycle: the combinational read of the flag byte, and the flag commit that the previous operation scheduled at the clock edge. The bench provokes this by issuing read-flags directly after a write-flags, after a carry-producing add, and after interrupt-enable changes. Each read must return the value committed at the edge just before it, never a stale or a look-ahead value. The second overlap is between `en` low and a flag-writing op. The bench judges it by reading the byte back through `flags` in the next cycle. A behavioural model runs alongside for a long pseudo-random op stream, with `en` toggling inside the same stream.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_NOT  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_RDF  = 4'd9,
    OP_WRF  = 4'd10,
    OP_IEN  = 4'd11,
    OP_IDIS = 4'd12,
    OP_R13  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } alu_op_e;

  // Field order fixes the flag byte layout: zf is bit 0, ie is bit 3
  typedef struct packed {
    logic ie;
    logic ov;
    logic cy;
    logic zf;
  } status_t;

  localparam int STATUS_W = $bits(status_t);

  function automatic logic op_is_arith(alu_op_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_CMP) ||
           (o == OP_INC) || (o == OP_DEC);
  endfunction

  function automatic logic op_is_logic(alu_op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR) || (o == OP_NOT);
  endfunction

  function automatic logic op_keeps_carry(alu_op_e o);
    return (o == OP_INC) || (o == OP_DEC);
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sum,
  output logic           carry,
  output logic           ovf
);

  logic [W-1:0] x_opnd, y_opnd;
  logic         c_in;
  logic [W:0]   wide;

  // One shared adder: subtraction feeds ~b with a carry-in of one,
  // increment and decrement use b against zero / all ones.
  always_comb begin
    x_opnd = a;
    y_opnd = b;
    c_in   = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin y_opnd = ~b; c_in = 1'b1; end
      OP_INC:         begin x_opnd = b; y_opnd = '0; c_in = 1'b1; end
      OP_DEC:         begin x_opnd = b; y_opnd = '1; c_in = 1'b0; end
      default:        ;
    endcase
  end

  assign wide = {1'b0, x_opnd} + {1'b0, y_opnd} + {{W{1'b0}}, c_in};
  assign sum  = wide[W-1:0];

  // For subtraction the adder carry is the inverse of the borrow
  always_comb begin
    if (op == OP_SUB || op == OP_CMP) carry = ~wide[W];
    else                              carry = wide[W];
  end

  assign ovf = (x_opnd[W-1] == y_opnd[W-1]) && (sum[W-1] != x_opnd[W-1]);

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lres
);

  always_comb begin
    unique case (op)
      OP_AND:  lres = a & b;
      OP_OR:   lres = a | b;
      OP_XOR:  lres = a ^ b;
      OP_NOT:  lres = ~a;
      default: lres = a;
    endcase
  end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  alu_op_e             op,
  input  logic [STATUS_W-1:0] wr_val,
  input  logic                val_zero,
  input  logic                cy_in,
  input  logic                ov_in,
  output status_t             st
);

  status_t st_nxt;

  always_comb begin
    st_nxt = st;
    if (op_is_arith(op)) begin
      st_nxt.zf = val_zero;
      st_nxt.ov = ov_in;
      if (!op_keeps_carry(op)) st_nxt.cy = cy_in;
    end else if (op_is_logic(op)) begin
      st_nxt.zf = val_zero;
      st_nxt.cy = 1'b0;
      st_nxt.ov = 1'b0;
    end else begin
      unique case (op)
        OP_WRF:  st_nxt = status_t'(wr_val);
        OP_IEN:  st_nxt.ie = 1'b1;
        OP_IDIS: st_nxt.ie = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st <= '0;
    else if (en) st <= st_nxt;
  end

  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st));

  p_ie_untouched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_is_arith(op) || op_is_logic(op) || op == OP_RDF)) |=> $stable(st.ie));

  p_ie_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_IEN) |=> st.ie);

  p_ie_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_IDIS) |=> !st.ie);

  p_logic_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_is_logic(op)) |=> (!st.cy && !st.ov));

  p_incdec_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_keeps_carry(op)) |=> $stable(st.cy));

  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= OP_R13) |=> $stable(st));

endmodule

// File: rtl/alu8_status_top.sv
module alu8_status_top
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [W-1:0] flags
);

  localparam int PAD_W = W - STATUS_W;

  alu_op_e      op_e;
  logic [W-1:0] ar_sum, lg_res, core_val;
  logic         ar_cy, ar_ov;
  status_t      st;

  assign op_e = alu_op_e'(op);

  alu8_arith #(.W(W)) u_arith (
    .op(op_e), .a(a), .b(b), .sum(ar_sum), .carry(ar_cy), .ovf(ar_ov)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op_e), .a(a), .b(b), .lres(lg_res)
  );

  assign core_val = op_is_logic(op_e) ? lg_res : ar_sum;

  alu8_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op_e),
    .wr_val(a[STATUS_W-1:0]), .val_zero(core_val == '0),
    .cy_in(ar_cy), .ov_in(ar_ov), .st(st)
  );

  assign flags = {{PAD_W{1'b0}}, st};

  always_comb begin
    if (op_is_arith(op_e) || op_is_logic(op_e)) result = core_val;
    else if (op_e == OP_RDF)                     result = flags;
    else                                         result = a;
  end

  assign result_we = (op_is_arith(op_e) && op_e != OP_CMP) ||
                     op_is_logic(op_e) || (op_e == OP_RDF);

  p_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_CMP || op_e == OP_SUB) |-> (ar_cy == (a < b)));

  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_ADD) |-> (ar_cy == (({1'b0, a} + {1'b0, b}) > {1'b0, {W{1'b1}}})));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_is_arith(op_e) || op_is_logic(op_e))) |=>
      (flags[0] == ($past(core_val) == '0)));

  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_CMP) |-> !result_we);

  p_high_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags[W-1:STATUS_W] == '0);

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (flags == '0));

endmodule

// File: tb/alu8_status_top_tb_top.sv
`timescale 1ns/1ps
module alu8_status_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'd0, b = 8'd0;
  logic [7:0] result;
  logic       result_we;
  logic [7:0] flags;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // behavioural flag model
  int mz = 0, mc = 0, mo = 0, mi = 0;

  always #2.5 clk = ~clk;

  alu8_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
    .result(result), .result_we(result_we), .flags(flags)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int o);
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5, 6: return "R5";
      7, 8: return "R6";
      9: return "R8";
      10: return "R9";
      11, 12: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int model_byte();
    return mi * 8 + mo * 4 + mc * 2 + mz;
  endfunction

  task automatic step(input bit e, input int o, input int av, input int bv);
    int er, ewe, raw, nz, nc, no, ni;
    string rq;
    @(negedge clk);
    en = e; op = o[3:0]; a = av[7:0]; b = bv[7:0];
    #1;
    rq = req_of(o);
    nz = mz; nc = mc; no = mo; ni = mi;
    raw = av;
    case (o)
      0: begin raw = (av + bv) & 255; nc = (av + bv) > 255;
               no = (sgn(av) + sgn(bv) > 127) || (sgn(av) + sgn(bv) < -128); end
      1, 2: begin raw = (av - bv) & 255; nc = av < bv;
               no = (sgn(av) - sgn(bv) > 127) || (sgn(av) - sgn(bv) < -128); end
      3: begin raw = av & bv; nc = 0; no = 0; end
      4: begin raw = av | bv; nc = 0; no = 0; end
      5: begin raw = av ^ bv; nc = 0; no = 0; end
      6: begin raw = (~av) & 255; nc = 0; no = 0; end
      7: begin raw = (bv + 1) & 255; no = (bv == 127); end
      8: begin raw = (bv - 1) & 255; no = (bv == 128); end
      10: begin nz = av & 1; nc = (av >> 1) & 1; no = (av >> 2) & 1; ni = (av >> 3) & 1; end
      11: ni = 1;
      12: ni = 0;
      default: ;
    endcase
    if (o <= 8) nz = (raw == 0);
    er  = (o == 9) ? model_byte() : raw;
    ewe = (o <= 9 && o != 2);
    chk(rq, "result_we", int'(result_we), ewe);
    if (ewe) chk(rq, "result", int'(result), er);
    @(posedge clk);
    if (e) begin mz = nz; mc = nc; mo = no; mi = ni; end
    #1;
    if (!e)          chk("R11", "flags (en low)", int'(flags), model_byte());
    else if (o <= 8) begin
      chk("R7", "zero flag", int'(flags[0]), mz);
      chk(rq, "flags", int'(flags), model_byte());
    end else         chk(rq, "flags", int'(flags), model_byte());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    #1;
    chk("R1", "flags in reset", int'(flags), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "flags after reset", int'(flags), 0);

    // directed corners
    step(1, 0, 8'h7F, 8'h01);   // R2 signed overflow
    step(1, 0, 8'hFF, 8'h01);   // R2 carry and zero
    step(1, 9, 0, 0);           // R8 read right after commit
    step(1, 1, 8'h00, 8'h01);   // R3 borrow
    step(1, 1, 8'h80, 8'h01);   // R3 overflow
    step(1, 2, 8'h42, 8'h42);   // R4 equal
    step(1, 2, 8'h10, 8'h20);   // R4 below
    step(1, 2, 8'h30, 8'h20);   // R4 above
    step(1, 0, 8'hF0, 8'h20);   // set carry before logic
    step(1, 3, 8'hF0, 8'h0F);   // R5 AND to zero
    step(1, 4, 8'hA0, 8'h05);   // R5 OR
    step(1, 5, 8'h5A, 8'h5A);   // R5 XOR zero
    step(1, 6, 8'hFF, 8'h00);   // R5 NOT zero
    step(1, 0, 8'hF0, 8'h20);   // carry set again
    step(1, 7, 8'h00, 8'h7F);   // R6 inc overflow, carry kept
    step(1, 7, 8'h00, 8'hFF);   // R6 inc wrap to zero
    step(1, 8, 8'h00, 8'h80);   // R6 dec overflow
    step(1, 8, 8'h00, 8'h01);   // R6 dec to zero
    step(1, 10, 8'hFF, 8'h00);  // R9 write all flags
    step(1, 9, 8'h00, 8'h00);   // R8 read back 0F
    step(1, 10, 8'h05, 8'h00);  // R9 write
    step(1, 9, 8'h00, 8'h00);
    step(1, 12, 8'h00, 8'h00);  // R10 clear ie
    step(1, 11, 8'h00, 8'h00);  // R10 set ie
    step(1, 0, 8'h01, 8'h01);   // R10 arith keeps ie
    step(1, 9, 8'h00, 8'h00);
    step(0, 10, 8'h00, 8'h00);  // R11 write blocked
    step(0, 12, 8'h00, 8'h00);  // R11 clear blocked
    step(1, 13, 8'h00, 8'h00);  // R12
    step(1, 14, 8'h12, 8'h34);  // R12
    step(1, 15, 8'h00, 8'h00);  // R12

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 256, $urandom % 256);
    end
    finish_run();
  end

endmodule